// File: doc/BRIEF.md
# SPI Master with Clock-Enable Timing

This block is a serial peripheral interface master that runs entirely on a single fast system clock. The serial clock is not a second clock. It is a level that the control logic toggles on clock-enable ticks from a half-period counter, and the divide ratio is taken from an input when a transfer starts. All four clock polarity and phase combinations are selected by a two-bit mode input. Words are `WORD_W` bits wide and are shifted most significant bit first.

The user starts a transfer by pulsing `wrEn` with a word on `wrData` while the block is idle. While a word is on the wire, the block raises `dataReq` for one cycle, `PREFETCH` cycles before the word's final internal clock edge. A word written before that edge is sent straight after the current one, with no gap and with chip select held low. If no word is written, chip select is released half a serial period after the last edge. Each received word appears on `rdData` with a one-cycle `rdValid` pulse.

The serial clock, MOSI and chip select leave through matching register stages (`PIPE` deep), so they stay in phase at the pins. The MISO sample enable is delayed by the same number of stages, so MISO is captured with no input register in the cycle in which the serial clock edge appears at the pin.

Top module: `spi_ce_master`

## Requirements
- R1: With CPHA = 0, each serial clock half-period lasts `divRatio >> 1` system cycles, so bit 0 is ignored. A result of 0 is treated as 1. Mode and ratio are latched when a transfer starts, and later changes have no effect on that transfer.
- R2: With CPHA = 1 (`spiMode[0]` = 1), the half-period is never shorter than 2 cycles. A computed half-period of 1 becomes 2.
- R3: While idle, `sck` equals CPOL (`spiMode[1]`). MOSI carries the word MSB first. With CPHA = 0 data is valid on the leading edge (the edge away from CPOL); with CPHA = 1 it is valid on the trailing edge.
- R4: MISO is shifted in MSB first on the same edges on which the slave samples MOSI. The assembled word is placed on `rdData` with `rdValid` high for exactly one cycle.
- R5: `csN` goes low one half-period before the first `sck` edge and returns high one half-period after the last edge. Sampling only happens while `csN` is low.
- R6: `dataReq` is a one-cycle pulse, raised once per word, `PREFETCH` cycles before the word's final internal edge. The first `rdValid` follows the first `dataReq` by `PREFETCH+PIPE+1` cycles when CPHA = 1, and by `PREFETCH+PIPE+1-h` cycles when CPHA = 0, where h is the half-period.
- R7: A word written while a word is in flight (no later than that word's last cycle) follows with no gap. `csN` stays low and every `sck` half-period stays equal across the word boundary.
- R8: If no word is pending at a word's end, the transfer stops after exactly 2·`WORD_W` `sck` edges.
- R9: `mosi` changes only in a cycle in which `sck` or `csN` also changes at the pins.
- R10: Reset drives `csN` high and `sck`, `dataReq` and `rdValid` low. A reset during a transfer aborts it, and the transfer does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is derived from it |
| rst | input | 1 | Synchronous reset, active high |
| spiMode | input | 2 | [1] clock polarity, [0] clock phase; latched at transfer start |
| divRatio | input | DIV_W | Serial clock divide ratio (even; bit 0 ignored) |
| wrData | input | WORD_W | Word to transmit |
| wrEn | input | 1 | Write strobe: starts a transfer, or queues the next word |
| dataReq | output | 1 | One-cycle request for the next word |
| rdData | output | WORD_W | Last received word |
| rdValid | output | 1 | One-cycle pulse when `rdData` is updated |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip select, active low |

## Verification
A write in the idle state starts the transfer at the next clock edge. Every pin reaction then lags the internal event by `PIPE` cycles. `rdValid` lags the last sample edge at the pin by one further cycle. `dataReq` is combinational from registered counters, so it is high during the cycle that ends `PREFETCH` edges before the word's final edge. The bench samples all outputs on the falling clock edge and records the cycle of every `csN`, `sck`, `dataReq` and `rdValid` event. It compares the distances between those events (setup, half-period, hold, request-to-valid) with values it computes from the half-period rule, instead of checking isolated instants. A slave model that reacts to the pin edges checks the word contents in both directions.

// File: rtl/spi_ce_pkg.sv
package spi_ce_pkg;

  // Strobes from the control FSM to the shift datapath, valid for one cycle.
  typedef struct packed {
    logic loadIn;      // load shift register from wrData
    logic loadHold;    // load shift register from the queued word
    logic holdWr;      // capture wrData into the queue register
    logic mosiTake;    // with a load: present the MSB at once (phase 0)
    logic shiftTx;     // present next MOSI bit
    logic sampleIn;    // sample edge of the serial clock
    logic lastSample;  // final sample edge of a word
    logic sckLvl;      // internal serial clock level
    logic sselLvl;     // internal select level, 1 = selected
  } spiStrobe_t;

endpackage

// File: rtl/spi_ce_ctrl.sv
module spi_ce_ctrl
  import spi_ce_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int DIV_W    = 8,
  parameter int PREFETCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       spiMode,
  input  logic [DIV_W-1:0] divRatio,
  output spiStrobe_t       strb,
  output logic             dataReq
);

  localparam int EDGES     = 2 * WORD_W;
  localparam int EDGE_W    = $clog2(EDGES);
  localparam int LAST_EDGE = EDGES - 1;
  localparam int CNT_W     = EDGE_W + DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD} state_t;

  state_t           state;
  logic [DIV_W-1:0] halfLat, halfCnt, halfReq;
  logic [EDGE_W-1:0] edgeCnt, lastSampEdge;
  logic [CNT_W-1:0] cyclesLeft, wordLenReq, wordLenLat;
  logic             cphaLat, sckReg, holdValid;
  logic             tick, lastEdge, goOn;

  // Half-period requested by the inputs: ratio/2, at least 1, at least 2 for phase 1.
  always_comb begin
    halfReq = divRatio >> 1;
    if (halfReq == '0) halfReq = DIV_W'(1);
    if (spiMode[0] && halfReq == DIV_W'(1)) halfReq = DIV_W'(2);
  end

  assign wordLenReq   = CNT_W'(EDGES) * CNT_W'(halfReq) - CNT_W'(1);
  assign wordLenLat   = CNT_W'(EDGES) * CNT_W'(halfLat) - CNT_W'(1);
  assign tick         = (halfCnt == halfLat - DIV_W'(1));
  assign lastEdge     = (edgeCnt == EDGE_W'(LAST_EDGE));
  assign lastSampEdge = cphaLat ? EDGE_W'(LAST_EDGE) : EDGE_W'(LAST_EDGE - 1);
  assign goOn         = wrEn || holdValid;
  assign dataReq      = (state == S_XFER) && (cyclesLeft == CNT_W'(PREFETCH));

  always_comb begin
    strb         = '0;
    strb.sckLvl  = (state == S_IDLE) ? spiMode[1] : sckReg;
    strb.sselLvl = (state != S_IDLE);
    case (state)
      S_IDLE: begin
        strb.loadIn   = wrEn;
        strb.mosiTake = wrEn && !spiMode[0];
      end
      S_XFER: begin
        strb.holdWr = wrEn;
        if (tick) begin
          strb.sampleIn   = (edgeCnt[0] == cphaLat);
          strb.lastSample = (edgeCnt == lastSampEdge);
          strb.shiftTx    = cphaLat ? !edgeCnt[0] : (edgeCnt[0] && !lastEdge);
          if (lastEdge && goOn) begin
            strb.loadIn   = wrEn;
            strb.loadHold = !wrEn;
            strb.mosiTake = !cphaLat;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      halfLat    <= DIV_W'(1);
      halfCnt    <= '0;
      edgeCnt    <= '0;
      cyclesLeft <= '0;
      cphaLat    <= 1'b0;
      sckReg     <= 1'b0;
      holdValid  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wrEn) begin
            state      <= S_XFER;
            cphaLat    <= spiMode[0];
            sckReg     <= spiMode[1];
            halfLat    <= halfReq;
            halfCnt    <= '0;
            edgeCnt    <= '0;
            cyclesLeft <= wordLenReq;
            holdValid  <= 1'b0;
          end
        end
        S_XFER: begin
          cyclesLeft <= cyclesLeft - CNT_W'(1);
          if (wrEn) holdValid <= 1'b1;
          if (tick) begin
            halfCnt <= '0;
            sckReg  <= !sckReg;
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (lastEdge) begin
              if (goOn) begin
                edgeCnt    <= '0;
                cyclesLeft <= wordLenLat;
                holdValid  <= 1'b0;
              end else begin
                state <= S_HOLD;
              end
            end
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        default: begin
          if (tick) begin
            state   <= S_IDLE;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  // R1
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> (halfCnt < halfLat));

  // R6
  word_end_align_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_XFER && tick && lastEdge) |-> (cyclesLeft == '0));

  // R6
  data_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dataReq |=> !dataReq);

endmodule

// File: rtl/spi_ce_datapath.sv
module spi_ce_datapath
  import spi_ce_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int PIPE   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  spiStrobe_t        strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              miso,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              csN,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);

  logic [WORD_W-1:0] txReg, holdData, rxReg, src, rxNext;
  logic              mosiReg;
  // Equal-depth stages keep clock, data, select and sample enable in phase.
  logic [PIPE-1:0]   sckP, mosiP, sselP, sampP, lastP;

  assign src     = strb.loadIn ? wrData : holdData;
  assign rxNext  = {rxReg[WORD_W-2:0], miso};
  assign sckOut  = sckP[PIPE-1];
  assign mosiOut = mosiP[PIPE-1];
  assign csN     = !sselP[PIPE-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      txReg    <= '0;
      holdData <= '0;
      rxReg    <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
      mosiReg  <= 1'b0;
      sckP     <= '0;
      mosiP    <= '0;
      sselP    <= '0;
      sampP    <= '0;
      lastP    <= '0;
    end else begin
      if (strb.holdWr) holdData <= wrData;

      if (strb.loadIn || strb.loadHold) begin
        if (strb.mosiTake) begin
          mosiReg <= src[WORD_W-1];
          txReg   <= src << 1;
        end else begin
          txReg <= src;
        end
      end else if (strb.shiftTx) begin
        mosiReg <= txReg[WORD_W-1];
        txReg   <= txReg << 1;
      end

      sckP[0]  <= strb.sckLvl;
      mosiP[0] <= mosiReg;
      sselP[0] <= strb.sselLvl;
      sampP[0] <= strb.sampleIn;
      lastP[0] <= strb.lastSample;
      for (int i = 1; i < PIPE; i++) begin
        sckP[i]  <= sckP[i-1];
        mosiP[i] <= mosiP[i-1];
        sselP[i] <= sselP[i-1];
        sampP[i] <= sampP[i-1];
        lastP[i] <= lastP[i-1];
      end

      rdValid <= 1'b0;
      if (sampP[PIPE-1]) rxReg <= rxNext;
      if (lastP[PIPE-1]) begin
        rdData  <= rxNext;
        rdValid <= 1'b1;
      end
    end
  end

  // R9
  mosi_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosiOut) |-> (!$stable(sckOut) || !$stable(csN)));

  // R4
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R5
  sample_selected_chk: assert property (@(posedge clk) disable iff (rst)
    sampP[PIPE-1] |-> !csN);

endmodule

// File: rtl/spi_ce_master.sv
module spi_ce_master
  import spi_ce_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int DIV_W    = 8,
  parameter int PREFETCH = 2,
  parameter int PIPE     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        spiMode,
  input  logic [DIV_W-1:0]  divRatio,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrEn,
  output logic              dataReq,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);

  if (PREFETCH < 1) begin : g_bad_prefetch
    $error("PREFETCH must be at least 1");
  end
  if (PIPE < 1) begin : g_bad_pipe
    $error("PIPE must be at least 1");
  end

  spiStrobe_t strb;

  spi_ce_ctrl #(
    .WORD_W(WORD_W), .DIV_W(DIV_W), .PREFETCH(PREFETCH)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .spiMode(spiMode),
    .divRatio(divRatio), .strb(strb), .dataReq(dataReq)
  );

  spi_ce_datapath #(
    .WORD_W(WORD_W), .PIPE(PIPE)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .miso(miso),
    .sckOut(sck), .mosiOut(mosi), .csN(csN), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/tb_spi_ce_master.sv
module tb_spi_ce_master;
  localparam int W = 8, DW = 8, PF = 2, PP = 1;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]    spiMode = 2'b00;
  logic [DW-1:0] divRatio = 8'd4;
  logic [W-1:0]  wrData = '0;
  logic          wrEn = 1'b0;
  logic          dataReq, rdValid, sck, mosi, csN;
  logic [W-1:0]  rdData;
  logic          miso = 1'b0;

  spi_ce_master #(.WORD_W(W), .DIV_W(DW), .PREFETCH(PF), .PIPE(PP)) dut (
    .clk(clk), .rst(rst), .spiMode(spiMode), .divRatio(divRatio),
    .wrData(wrData), .wrEn(wrEn), .dataReq(dataReq), .rdData(rdData),
    .rdValid(rdValid), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN)
  );

  int errCnt = 0, chkCnt = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Slave model reacting to pin edges
  logic bCpol = 1'b0, bCpha = 1'b0;
  logic [15:0] sSeq = '0;
  logic [7:0]  sRx = '0;
  logic [7:0]  sGot [2];
  int sPos = 0, sBits = 0, sGotCnt = 0;

  always @(negedge csN) begin
    sPos = 0; sBits = 0; sGotCnt = 0;
    if (!bCpha) begin miso = sSeq[15]; sPos = 1; end
  end

  always @(sck) begin
    if (csN === 1'b0) begin
      if ((sck != bCpol) != bCpha) begin
        sRx = {sRx[6:0], mosi};
        sBits++;
        if (sBits == 8) begin
          if (sGotCnt < 2) sGot[sGotCnt] = sRx;
          sGotCnt++;
          sBits = 0;
        end
      end else if (sPos < 16) begin
        miso = sSeq[15 - sPos];
        sPos++;
      end
    end
  end

  // Event monitor on the falling edge
  int cyc = 0, csRise = 0, csFall = 0, csRises = 0, togCnt = 0, firstT = 0, lastT = 0;
  int minI = 0, maxI = 0, reqCnt = 0, firstReq = 0, rdCnt = 0, firstRd = 0, misalign = 0;
  logic pSck = 1'b0, pCs = 1'b1, pMosi = 1'b0;
  logic [7:0] rdGot [2];

  always @(negedge clk) begin
    cyc++;
    if (csN != pCs) begin
      if (!csN) csFall = cyc;
      else begin csRise = cyc; csRises++; end
    end
    if (sck != pSck && !csN) begin
      if (togCnt == 0) firstT = cyc;
      else begin
        if (togCnt == 1 || cyc - lastT < minI) minI = cyc - lastT;
        if (togCnt == 1 || cyc - lastT > maxI) maxI = cyc - lastT;
      end
      lastT = cyc;
      togCnt++;
    end
    if (mosi != pMosi && sck == pSck && csN == pCs) misalign++;
    if (dataReq) begin
      if (reqCnt == 0) firstReq = cyc;
      reqCnt++;
    end
    if (rdValid) begin
      if (rdCnt < 2) rdGot[rdCnt] = rdData;
      if (rdCnt == 0) firstRd = cyc;
      rdCnt++;
    end
    pSck = sck; pCs = csN; pMosi = mosi;
  end

  task automatic clearMon();
    csRises = 0; togCnt = 0; reqCnt = 0; rdCnt = 0; misalign = 0;
    minI = 0; maxI = 0;
  endtask

  function automatic int halfOf(input logic [1:0] m, input logic [7:0] d);
    int h = int'(d) / 2;
    if (h == 0) h = 1;
    if (m[0] && h == 1) h = 2;
    return h;
  endfunction

  // {mode[42:41], div[40:33], two[32], m0[31:24], m1[23:16], s0[15:8], s1[7:0]}
  localparam logic [42:0] VECS [8] = '{
    {2'd0, 8'd4, 1'b1, 8'hA5, 8'h3C, 8'h5A, 8'hC3},
    {2'd1, 8'd2, 1'b1, 8'h96, 8'hE1, 8'h0F, 8'hF0},
    {2'd2, 8'd6, 1'b0, 8'h81, 8'h00, 8'h7E, 8'h00},
    {2'd3, 8'd8, 1'b1, 8'h12, 8'h34, 8'hAB, 8'hCD},
    {2'd0, 8'd2, 1'b1, 8'hFF, 8'h00, 8'h01, 8'h80},
    {2'd1, 8'd5, 1'b0, 8'h6B, 8'h00, 8'hD4, 8'h00},
    {2'd2, 8'd0, 1'b1, 8'hC6, 8'h39, 8'h55, 8'hAA},
    {2'd3, 8'd3, 1'b0, 8'h2D, 8'h00, 8'hB2, 8'h00}
  };

  task automatic runVec(input logic [42:0] v, input bit perturb);
    logic [1:0] m = v[42:41];
    logic [7:0] d = v[40:33];
    bit two = v[32];
    int h = halfOf(v[42:41], v[40:33]);
    int t = 0, expDist;
    bit answered = 1'b0;
    @(negedge clk);
    spiMode = m; divRatio = d; bCpol = m[1]; bCpha = m[0];
    sSeq = {v[15:8], v[7:0]};
    repeat (3) @(negedge clk);
    clearMon();
    chk(sck == m[1], "R3", "idle sck level", int'(sck), int'(m[1]));
    wrData = v[31:24]; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (perturb) begin spiMode = ~m; divRatio = 8'd12; end
    while (csRises == 0 && t < 3000) begin
      if (dataReq && two && !answered) begin
        wrData = v[23:16]; wrEn = 1'b1; answered = 1'b1;
        @(negedge clk);
        wrEn = 1'b0;
      end else begin
        @(negedge clk);
      end
      t++;
    end
    repeat (2) @(negedge clk);
    if (perturb) chk(minI == h && maxI == h, "R1", "half-period after input change", maxI, h);
    else if (m[0] && d < 8'd4) chk(minI == h && maxI == h, "R2", "phase-1 half-period", minI, h);
    else chk(minI == h, "R1", "half-period", minI, h);
    chk(firstT - csFall == h, "R5", "select to first edge", firstT - csFall, h);
    chk(csRise - lastT == h, "R5", "last edge to release", csRise - lastT, h);
    chk(sGot[0] == v[31:24], "R3", "slave got word 0", int'(sGot[0]), int'(v[31:24]));
    chk(rdGot[0] == v[15:8], "R4", "master got word 0", int'(rdGot[0]), int'(v[15:8]));
    expDist = PF + PP + 1 - (m[0] ? 0 : h);
    chk(firstRd - firstReq == expDist, "R6", "request to valid", firstRd - firstReq, expDist);
    chk(reqCnt == (two ? 2 : 1), "R6", "request count", reqCnt, two ? 2 : 1);
    chk(misalign == 0, "R9", "mosi change without sck", misalign, 0);
    if (two) begin
      chk(togCnt == 32 && csRises == 1, "R7", "edges over two words", togCnt, 32);
      chk(maxI == h, "R7", "uniform half-period", maxI, h);
      chk(sGot[1] == v[23:16], "R7", "slave got word 1", int'(sGot[1]), int'(v[23:16]));
      chk(rdGot[1] == v[7:0], "R4", "master got word 1", int'(rdGot[1]), int'(v[7:0]));
    end else begin
      chk(togCnt == 16, "R8", "edges for one word", togCnt, 16);
      chk(csN == 1'b1 && rdCnt == 1, "R8", "transfer ended", int'(csN), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R10", "csN in reset", int'(csN), 1);
    chk(sck == 1'b0, "R10", "sck in reset", int'(sck), 0);
    chk(dataReq == 1'b0, "R10", "dataReq in reset", int'(dataReq), 0);
    chk(rdValid == 1'b0, "R10", "rdValid in reset", int'(rdValid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) runVec(VECS[i], 1'b0);

    // Latched mode and ratio: inputs changed mid-transfer are ignored (R1)
    runVec({2'd0, 8'd4, 1'b0, 8'h5C, 8'h00, 8'hE7, 8'h00}, 1'b1);

    // Reset in the middle of a transfer (R10)
    @(negedge clk);
    spiMode = 2'd0; divRatio = 8'd8; bCpol = 1'b0; bCpha = 1'b0;
    wrData = 8'h77; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R10", "csN after mid-transfer reset", int'(csN), 1);
    chk(sck == 1'b0, "R10", "sck after mid-transfer reset", int'(sck), 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(csN == 1'b1 && dataReq == 1'b0, "R10", "no resumption after reset", int'(csN), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule